// File: doc/BRIEF.md
# Memory Bus Address Decoder with One-Shot Boot Overlay

This block sits between an 8-bit processor with a 16-bit address bus and the memories behind it. Each cycle it may receive one request. It turns that request into a one-hot region select, a local offset into the selected memory, a qualified write strobe and a pass-through of the write data. The memories are outside the block. They are synchronous arrays that present their read word one clock after a select. The block registers which region a read went to and steers that memory's word onto the processor's read-data port, so read data is valid one clock after the request.

After reset, a small boot ROM is laid over the bottom of the cartridge ROM window. The processor switches this overlay off itself by reading the last boot byte. A write to that address does not switch it off, and once it is off it stays off until the next reset. Video, external and work RAM are indexed through a 13-bit mask. The work-RAM echo range reaches the same cells through that mask. The object-attribute window and the I/O window have no memory behind them here, so they read as zero and discard writes.

Top module: `mem_bus_decoder`

## Requirements
- R1: While `rst_n` is low and after it is released, `overlay_on` is 1.
- R2: While `overlay_on` is 1, a read of 0x0000–0x00FE selects the boot ROM (`rgn_sel` bit 0) with `mem_addr` equal to the address. A read of 0x00FF selects cartridge ROM.
- R3: A read of 0x00FE returns the boot byte, and `overlay_on` is 0 from the next clock onward. A write to 0x00FE leaves the flag set. Once clear, the flag stays clear until reset, and reads of 0x0000–0x00FE then go to cartridge ROM.
- R4: A read of 0x0000–0x7FFF that is not served by the overlay selects cartridge ROM (`rgn_sel` bit 1), with `mem_addr` equal to address bits 14:0. A write anywhere in 0x0000–0x7FFF asserts no select and no `mem_we`.
- R5: An access to 0x8000–0x9FFF selects video RAM (`rgn_sel` bit 2) with offset address AND 0x1FFF. Video RAM can be read and written.
- R6: An access to 0xA000–0xBFFF selects external RAM (`rgn_sel` bit 3) with offset address AND 0x1FFF. External RAM can be read and written.
- R7: An access to 0xC000–0xFDFF selects work RAM (`rgn_sel` bit 4) with offset address AND 0x1FFF. A write through the echo range can therefore be read back at the matching main address, and the reverse also holds.
- R8: An access to 0xFE00–0xFEFF or 0xFF00–0xFF7F asserts no select and no `mem_we`. A read there returns 0x00 on the following cycle.
- R9: An access to 0xFF80–0xFFFF selects high RAM (`rgn_sel` bit 5) with offset equal to address bits 6:0. High RAM can be read and written.
- R10: `rgn_sel` has at most one bit set. `bus_rdata` carries the selected memory's word in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after a read request |
| overlay_on | output | 1 | Boot overlay active flag |
| rgn_sel | output | 6 | One-hot region select: boot, cart, video, external, work, high RAM |
| mem_addr | output | 16 | Local offset into the selected memory |
| mem_we | output | 1 | Write strobe for the selected memory |
| mem_wdata | output | 8 | Write data to memories |
| mem_rdata | input | 48 | Registered read words of the six memories, region i in bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: 8-bit data, a 13-bit RAM mask, a 7-bit high-RAM index and 0xFE as the last boot byte. With these values the hand-off sits at 0x00FE, right next to 0x00FF, which the overlay never covers. The echo range's top cell 0xFDFF aliases 0xDDFF, and the high-RAM and I/O windows meet at 0xFF7F/0xFF80. The bench's memory model keys its storage on the offset the block produces, so any aliasing or masking error shows up as a wrong read-back.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ADDR_W  = 16;
  localparam int RG_N    = 6;
  localparam int RG_BOOT = 0;
  localparam int RG_CART = 1;
  localparam int RG_VRAM = 2;
  localparam int RG_XRAM = 3;
  localparam int RG_WRAM = 4;
  localparam int RG_HRAM = 5;
endpackage

// File: rtl/mbd_region_decode.sv
module mbd_region_decode
  import mbd_pkg::*;
#(
  parameter int       RAM_AW    = 13,
  parameter int       HRAM_AW   = 7,
  parameter bit [7:0] BOOT_LAST = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              overlay,
  output logic [RG_N-1:0]   sel,
  output logic [ADDR_W-1:0] offset,
  output logic              wr_ok
);
  localparam int ROM_AW = ADDR_W - 1;

  logic [RG_N-1:0] sel_raw;
  logic            writable;
  logic            in_boot;

  assign in_boot = overlay && (addr[15:8] == 8'h00) && (addr[7:0] <= BOOT_LAST);

  always_comb begin
    sel_raw  = '0;
    offset   = '0;
    writable = 1'b0;
    unique case (addr[15:13])
      3'b000, 3'b001, 3'b010, 3'b011: begin
        if (!we) begin
          if (in_boot) begin
            sel_raw[RG_BOOT] = 1'b1;
            offset           = ADDR_W'(addr[7:0]);
          end else begin
            sel_raw[RG_CART] = 1'b1;
            offset           = ADDR_W'(addr[ROM_AW-1:0]);
          end
        end
      end
      3'b100: begin
        sel_raw[RG_VRAM] = 1'b1;
        offset           = ADDR_W'(addr[RAM_AW-1:0]);
        writable         = 1'b1;
      end
      3'b101: begin
        sel_raw[RG_XRAM] = 1'b1;
        offset           = ADDR_W'(addr[RAM_AW-1:0]);
        writable         = 1'b1;
      end
      3'b110: begin
        sel_raw[RG_WRAM] = 1'b1;
        offset           = ADDR_W'(addr[RAM_AW-1:0]);
        writable         = 1'b1;
      end
      default: begin
        if (addr[12:9] != 4'hF) begin
          sel_raw[RG_WRAM] = 1'b1;
          offset           = ADDR_W'(addr[RAM_AW-1:0]);
          writable         = 1'b1;
        end else if (addr[8] && addr[7]) begin
          sel_raw[RG_HRAM] = 1'b1;
          offset           = ADDR_W'(addr[HRAM_AW-1:0]);
          writable         = 1'b1;
        end
      end
    endcase
  end

  assign sel   = req ? sel_raw : '0;
  assign wr_ok = req & we & writable;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R10
  AST_ROM_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !addr[15]) |-> (sel == '0 && !wr_ok)); // R4
  AST_ECHO_TO_WRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr >= 16'hE000 && addr < 16'hFE00) |-> (sel[RG_WRAM] && offset < 16'h2000)); // R7
  AST_DEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr >= 16'hFE00 && addr < 16'hFF80) |-> (sel == '0 && !wr_ok)); // R8
endmodule

// File: rtl/mbd_boot_flag.sv
module mbd_boot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic active
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clear) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign active = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |=> !flag_q); // R3
endmodule

// File: rtl/mbd_rdata_mux.sv
module mbd_rdata_mux
  import mbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic [RG_N-1:0]        sel,
  input  logic [RG_N*DATA_W-1:0] words,
  output logic [DATA_W-1:0]      rdata
);
  logic [RG_N-1:0]   last_q;
  logic [RG_N-1:0]   last_d;
  logic [DATA_W-1:0] lane [RG_N];

  always_comb begin
    last_d = '0;
    if (rd_req) last_d = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  for (genvar g = 0; g < RG_N; g++) begin : g_lane
    assign lane[g] = last_q[g] ? words[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < RG_N; i++) rdata = rdata | lane[i];
  end

  AST_LAST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(last_q)); // R10
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sel == '0) |=> (rdata == '0)); // R8
endmodule

// File: rtl/mem_bus_decoder.sv
module mem_bus_decoder
  import mbd_pkg::*;
#(
  parameter int       DATA_W    = 8,
  parameter int       RAM_AW    = 13,
  parameter int       HRAM_AW   = 7,
  parameter bit [7:0] BOOT_LAST = 8'hFE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   overlay_on,
  output logic [RG_N-1:0]        rgn_sel,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_we,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [RG_N*DATA_W-1:0] mem_rdata
);
  logic boot_done;
  logic rd_req;

  mbd_region_decode #(
    .RAM_AW   (RAM_AW),
    .HRAM_AW  (HRAM_AW),
    .BOOT_LAST(BOOT_LAST)
  ) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (bus_req),
    .we     (bus_we),
    .addr   (bus_addr),
    .overlay(overlay_on),
    .sel    (rgn_sel),
    .offset (mem_addr),
    .wr_ok  (mem_we)
  );

  assign boot_done = rgn_sel[RG_BOOT] & ~bus_we & (bus_addr[7:0] == BOOT_LAST);
  assign rd_req    = bus_req & ~bus_we;
  assign mem_wdata = bus_wdata;

  mbd_boot_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (boot_done),
    .active(overlay_on)
  );

  mbd_rdata_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .sel   (rgn_sel),
    .words (mem_rdata),
    .rdata (bus_rdata)
  );

  AST_BOOT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == {8'h00, BOOT_LAST} && overlay_on) |=> !overlay_on); // R3
  AST_WRITE_KEEPS_OVERLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && overlay_on) |=> overlay_on); // R3
  AST_OVERLAY_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_sel[RG_BOOT] |-> (overlay_on && bus_addr[15:8] == 8'h00)); // R2
endmodule

// File: tb/mem_bus_decoder_bench.sv
module mem_bus_decoder_bench;
  import mbd_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              overlay_on;
  logic [RG_N-1:0]   rgn_sel;
  logic [15:0]       mem_addr;
  logic              mem_we;
  logic [DW-1:0]     mem_wdata;
  logic [RG_N*DW-1:0] mem_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bus_decoder u_mem_bus_decoder (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .overlay_on(overlay_on), .rgn_sel(rgn_sel), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] boot_f(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] cart_f(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction

  // Memory model: registered read, storage keyed by region and offset.
  logic [7:0] store [int];
  logic [7:0] q [RG_N];
  always @(posedge clk) begin
    for (int i = 0; i < RG_N; i++) begin
      if (rgn_sel[i]) begin
        if (mem_we) store[i*65536 + int'(mem_addr)] = mem_wdata;
        else if (i == RG_BOOT) q[i] <= boot_f(mem_addr);
        else if (i == RG_CART) q[i] <= cart_f(mem_addr);
        else if (store.exists(i*65536 + int'(mem_addr))) q[i] <= store[i*65536 + int'(mem_addr)];
        else q[i] <= 8'h00;
      end
    end
  end
  always_comb
    for (int i = 0; i < RG_N; i++) mem_rdata[i*DW +: DW] = q[i];

  typedef struct packed {
    logic        we;
    logic [15:0] a;
    logic [7:0]  d;
    logic [7:0]  exp;
    logic [3:0]  rq;
  } vec_t;
  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0010, 8'h00, boot_f(16'h0010), 4'd2},  // R2 overlay read
    '{1'b0, 16'h00FF, 8'h00, cart_f(16'h00FF), 4'd2},  // R2 just past overlay
    '{1'b1, 16'h00FE, 8'h12, 8'h00,            4'd3},  // R3 write must not clear
    '{1'b0, 16'h0000, 8'h00, boot_f(16'h0000), 4'd3},  // R3 still overlaid
    '{1'b0, 16'h00FE, 8'h00, boot_f(16'h00FE), 4'd3},  // R3 hand-off read
    '{1'b0, 16'h00FE, 8'h00, cart_f(16'h00FE), 4'd3},  // R3 now cartridge
    '{1'b0, 16'h0010, 8'h00, cart_f(16'h0010), 4'd3},
    '{1'b1, 16'h1234, 8'h55, 8'h00,            4'd4},  // R4 ROM write dropped
    '{1'b0, 16'h1234, 8'h00, cart_f(16'h1234), 4'd4},
    '{1'b0, 16'h7FFF, 8'h00, cart_f(16'h7FFF), 4'd4},
    '{1'b1, 16'h9ABC, 8'h22, 8'h00,            4'd5},  // R5 video RAM
    '{1'b0, 16'h9ABC, 8'h00, 8'h22,            4'd5},
    '{1'b1, 16'h8000, 8'h3C, 8'h00,            4'd5},
    '{1'b0, 16'h8000, 8'h00, 8'h3C,            4'd5},
    '{1'b1, 16'hA001, 8'h33, 8'h00,            4'd6},  // R6 external RAM
    '{1'b0, 16'hA001, 8'h00, 8'h33,            4'd6},
    '{1'b1, 16'hBFFF, 8'h44, 8'h00,            4'd6},
    '{1'b0, 16'hBFFF, 8'h00, 8'h44,            4'd6},
    '{1'b1, 16'hC100, 8'h5A, 8'h00,            4'd7},  // R7 main write, echo read
    '{1'b0, 16'hE100, 8'h00, 8'h5A,            4'd7},
    '{1'b1, 16'hFDFF, 8'h66, 8'h00,            4'd7},  // R7 echo top cell
    '{1'b0, 16'hDDFF, 8'h00, 8'h66,            4'd7},
    '{1'b1, 16'hD000, 8'h77, 8'h00,            4'd7},
    '{1'b0, 16'hF000, 8'h00, 8'h77,            4'd7},
    '{1'b1, 16'hFE10, 8'h88, 8'h00,            4'd8},  // R8 object window
    '{1'b0, 16'hFE10, 8'h00, 8'h00,            4'd8},
    '{1'b1, 16'hFF00, 8'h99, 8'h00,            4'd8},  // R8 I/O window
    '{1'b0, 16'hFF00, 8'h00, 8'h00,            4'd8},
    '{1'b0, 16'hFF7F, 8'h00, 8'h00,            4'd8},
    '{1'b1, 16'hFF80, 8'hA1, 8'h00,            4'd9},  // R9 high RAM
    '{1'b0, 16'hFF80, 8'h00, 8'hA1,            4'd9},
    '{1'b1, 16'hFFFF, 8'hB2, 8'h00,            4'd9},
    '{1'b0, 16'hFFFF, 8'h00, 8'hB2,            4'd9}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RG_N; i++) q[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(overlay_on == 1'b1, "R1 in reset", overlay_on, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(overlay_on == 1'b1, "R1 after release", overlay_on, 1);

    // R2 select and offset of an overlay read
    drive(1'b0, 16'h00FE, 8'h00);
    // drive leaves us just after the negedge: inspect selects before the edge
    #1;
    check(rgn_sel == 6'b000001, "R2 boot select", rgn_sel, 6'b000001);
    check(mem_addr == 16'h00FE, "R2 boot offset", mem_addr, 16'h00FE);
    bus_addr = 16'h0040; bus_we = 1'b1;  // turn the access into a harmless ROM write
    idle();
    check(overlay_on == 1'b1, "R3 write kept flag", overlay_on, 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].we, VECS[v].a, VECS[v].d);
      idle();
      if (!VECS[v].we)
        check(bus_rdata == VECS[v].exp, $sformatf("R%0d vec %0d", VECS[v].rq, v),
              bus_rdata, VECS[v].exp);
    end
    check(overlay_on == 1'b0, "R3 flag cleared", overlay_on, 0);

    // R4 ROM write asserts nothing
    drive(1'b1, 16'h0100, 8'hEE); #1;
    check(rgn_sel == '0 && !mem_we, "R4 write strobe", {rgn_sel, mem_we}, 0);
    // R8 object-window write asserts nothing
    bus_addr = 16'hFE80; #1;
    check(rgn_sel == '0 && !mem_we, "R8 write strobe", {rgn_sel, mem_we}, 0);
    // R9 high-RAM offset
    bus_addr = 16'hFFC5; #1;
    check(rgn_sel == 6'b100000 && mem_addr == 16'h0045 && mem_we,
          "R9 high offset", mem_addr, 16'h0045);
    // R7 echo offset
    bus_addr = 16'hE100; bus_we = 1'b0; #1;
    check(rgn_sel == 6'b010000 && mem_addr == 16'h0100, "R7 echo offset", mem_addr, 16'h0100);
    idle();
    // R10 echo read data visible the cycle after
    check(bus_rdata == 8'h5A, "R10 read latency", bus_rdata, 8'h5A);
    // R7 echo write seen at main address
    drive(1'b1, 16'hE345, 8'hC3); idle();
    drive(1'b0, 16'hC345, 8'h00); idle();
    check(bus_rdata == 8'hC3, "R7 echo write", bus_rdata, 8'hC3);
    // R4 cartridge offset after hand-off
    drive(1'b0, 16'h0005, 8'h00); #1;
    check(rgn_sel == 6'b000010 && mem_addr == 16'h0005, "R4 cart select", rgn_sel, 6'b000010);
    idle();
    check(bus_rdata == cart_f(16'h0005), "R4 cart data", bus_rdata, cart_f(16'h0005));

    // R1 second reset restores the overlay
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(overlay_on == 1'b1, "R1 re-reset", overlay_on, 1);
    rst_n = 1'b1;
    drive(1'b0, 16'h0005, 8'h00); idle();
    check(bus_rdata == boot_f(16'h0005), "R2 overlay after reset", bus_rdata, boot_f(16'h0005));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule